// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block holds the raw interrupt status of a display refresh controller in one 32-bit register on a simple register bus. Four event sources feed it. The first is an error response seen by the refresh DMA master. The second is the entry into a selectable vertical timing phase. The third is a frame base address handoff from either panel, and the fourth is a read from an empty FIFO on either panel. Each event sets a sticky status bit. Software clears a bit by writing 1 to it.

A mask register with the same bit layout gates the status bits onto a single interrupt line. A read-only masked view shows which enabled sources are pending. While the bus error bit is set, an error-state output is driven to the DMA master, and it stays high until software clears that bit. The timing generator, the DMA engine, the FIFOs and the bus interconnect are outside the block and appear as plain input strobes.

Top module: `lcd_irq_status`

## Requirements
- R1: After a synchronous active-low reset, the status register, the mask register and the read data are 0, and `irq_o` and `err_state_o` are low.
- R2: In every register, bits 31:5 and bit 0 read as 0, and writing them has no effect.
- R3: A write to the status register at offset 0x20 clears each of bits 4:1 whose write-data bit is 1. A bit whose write-data bit is 0 is left unchanged.
- R4: When a set event and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 3 sets only in the first cycle in which `vphase_i` equals `vsel_i`. The encoding is 00 sync, 01 back porch, 10 active video, 11 front porch. The previous phase counts as 00 right after reset. Staying inside the phase does not set the bit again.
- R6: Status bit 2 sets when `upper_load_i` or `lower_load_i` is high.
- R7: Status bit 1 sets when `upper_uf_i` or `lower_uf_i` is high.
- R8: Status bit 4 sets when `mst_err_i` is high. `err_state_o` follows that bit, so it stays high until software clears it.
- R9: The mask register at offset 0x1C is read/write for bits 4:1.
- R10: `irq_o` is the OR of status bits 4:1 ANDed with mask bits 4:1. Offset 0x24 reads that AND bit by bit, and writes to 0x24 are ignored.
- R11: Read data appears on `bus_rdata_o` in the cycle after the read strobe and shows the state before that edge. Unmapped offsets and cycles without a read give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| vsel_i | input | 2 | Vertical compare phase select |
| vphase_i | input | 2 | Current vertical phase |
| upper_load_i | input | 1 | Upper panel base copied to current address |
| lower_load_i | input | 1 | Lower panel base copied to current address |
| upper_uf_i | input | 1 | Upper panel FIFO read while empty |
| lower_uf_i | input | 1 | Lower panel FIFO read while empty |
| mst_err_i | input | 1 | DMA master received an error response |
| err_state_o | output | 1 | Master held in error state |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions treat every event input as a level that is sampled on each clock edge; they do not assume single-cycle pulses. The clear-check assertion is written only for cycles in which `mst_err_i` is low while the clear write occurs, because in the other cycles the set-wins rule applies. The stimulus drives every input at the falling clock edge. Each test case sets up the case where an event and a clear collide on purpose, and a behavioural reference model checks that case; the assertion is not used for it.

// File: rtl/lcd_irq_status.sv
module lcd_irq_status #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 8'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 8'h20,
  parameter logic [ADDR_W-1:0] MSTAT_OFS = 8'h24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [1:0]        vsel_i,
  input  logic [1:0]        vphase_i,
  input  logic              upper_load_i,
  input  logic              lower_load_i,
  input  logic              upper_uf_i,
  input  logic              lower_uf_i,
  input  logic              mst_err_i,
  output logic              err_state_o,
  output logic              irq_o
);

  logic [4:1]        stat_q, mask_q;
  logic [1:0]        phase_q;
  logic [DATA_W-1:0] rdata_q, rd_word;
  logic              unused_wdata;

  wire wr_stat = bus_sel_i && bus_wr_i && (bus_addr_i == STAT_OFS);
  wire wr_mask = bus_sel_i && bus_wr_i && (bus_addr_i == MASK_OFS);
  wire rd_en   = bus_sel_i && !bus_wr_i;

  wire       vcmp_hit = (vphase_i == vsel_i) && (phase_q != vsel_i);
  wire [4:1] set_v = {mst_err_i, vcmp_hit,
                      upper_load_i | lower_load_i,
                      upper_uf_i | lower_uf_i};
  wire [4:1] clr_v = wr_stat ? bus_wdata_i[4:1] : 4'b0;

  assign unused_wdata = ^{bus_wdata_i[DATA_W-1:5], bus_wdata_i[0]};

  always_comb begin
    rd_word = '0;
    if (bus_addr_i == STAT_OFS)       rd_word[4:1] = stat_q;
    else if (bus_addr_i == MASK_OFS)  rd_word[4:1] = mask_q;
    else if (bus_addr_i == MSTAT_OFS) rd_word[4:1] = stat_q & mask_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      mask_q  <= '0;
      phase_q <= '0;
      rdata_q <= '0;
    end else begin
      stat_q  <= (stat_q & ~clr_v) | set_v;
      phase_q <= vphase_i;
      rdata_q <= rd_en ? rd_word : '0;
      if (wr_mask) mask_q <= bus_wdata_i[4:1];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign err_state_o = stat_q[4];
  assign irq_o       = |(stat_q & mask_q);

endmodule

module lcd_irq_status_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              upper_load_i,
  input logic              lower_load_i,
  input logic              upper_uf_i,
  input logic              lower_uf_i,
  input logic              mst_err_i,
  input logic              err_state_o,
  input logic              irq_o,
  input logic [4:1]        stat_q,
  input logic [4:1]        mask_q
);
  logic unused_chk;
  assign unused_chk = ^{bus_wdata_i[DATA_W-1:5], bus_wdata_i[3:0]};

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:5] == '0 && !bus_rdata_o[0]);
  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_wr_i && bus_addr_i == STAT_OFS && bus_wdata_i[4] && !mst_err_i)
    |=> !err_state_o);
  // R6
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upper_load_i || lower_load_i) |=> stat_q[2]);
  // R7
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upper_uf_i || lower_uf_i) |=> stat_q[1]);
  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_err_i |=> err_state_o);
  // R10
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 4'b0) |-> !irq_o);
  // R11
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |=> bus_rdata_o == '0);
endmodule

bind lcd_irq_status lcd_irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .upper_load_i(upper_load_i), .lower_load_i(lower_load_i),
  .upper_uf_i(upper_uf_i), .lower_uf_i(lower_uf_i), .mst_err_i(mst_err_i),
  .err_state_o(err_state_o), .irq_o(irq_o), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/lcd_irq_status_tb.sv
module lcd_irq_status_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        sel = 0, wr = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [1:0]  vsel = 0, vphase = 0;
  logic        ul = 0, ll = 0, uu = 0, lu = 0, merr = 0;
  logic        err_st, irq;

  int checks = 0, errors = 0;
  int m_stat = 0, m_mask = 0, m_prev = 0, m_rdata = 0;

  always #4 clk = ~clk;

  lcd_irq_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .vsel_i(vsel), .vphase_i(vphase), .upper_load_i(ul), .lower_load_i(ll),
    .upper_uf_i(uu), .lower_uf_i(lu), .mst_err_i(merr),
    .err_state_o(err_st), .irq_o(irq));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int rd_model(int a);
    if (a == 'h20) return m_stat;
    if (a == 'h1C) return m_mask;
    if (a == 'h24) return m_stat & m_mask;
    return 0;
  endfunction

  task automatic cyc();
    int set_v, clr_v;
    @(posedge clk);
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_prev = 0; m_rdata = 0;
    end else begin
      m_rdata = (sel && !wr) ? rd_model(int'(addr)) : 0;
      set_v = (merr << 4) | (((int'(vphase) == int'(vsel)) && (m_prev != int'(vsel))) << 3)
            | ((ul | ll) << 2) | ((uu | lu) << 1);
      clr_v = (sel && wr && addr == 8'h20) ? (int'(wdata) & 'h1E) : 0;
      m_stat = (m_stat & ~clr_v) | set_v;
      if (sel && wr && addr == 8'h1C) m_mask = int'(wdata) & 'h1E;
      m_prev = int'(vphase);
    end
    #1;
    if (rst_n) begin
      check("R11 rdata model", rdata, m_rdata);
      check("R10 irq model", {31'b0, irq}, {31'b0, (m_stat & m_mask) != 0});
      check("R8 err_state model", {31'b0, err_st}, {31'b0, m_stat[4]});
    end
    @(negedge clk);
    sel = 0; wr = 0; ul = 0; ll = 0; uu = 0; lu = 0; merr = 0; wdata = 0;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic rd_reg(logic [7:0] a, logic [31:0] exp, string tag);
    sel = 1; wr = 0; addr = a; cyc();
    check(tag, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc();
    check("R1 reset rdata", rdata, 0);
    check("R1 reset irq", {31'b0, irq}, 0);
    check("R1 reset err_state", {31'b0, err_st}, 0);
    rst_n = 1;
    rd_reg(8'h20, 0, "R1 status after reset");
    rd_reg(8'h1C, 0, "R1 mask after reset");

    uu = 1; cyc();
    rd_reg(8'h20, 32'h2, "R7 upper underflow");
    wr_reg(8'h20, 32'h2);
    rd_reg(8'h20, 0, "R3 clear underflow");
    lu = 1; cyc();
    rd_reg(8'h20, 32'h2, "R7 lower underflow");
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h20, 32'h2, "R3 write zero keeps bit");
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_reg(8'h20, 0, "R3 clear all");

    ul = 1; cyc();
    rd_reg(8'h20, 32'h4, "R6 upper base load");
    wr_reg(8'h20, 32'h4);
    ll = 1; cyc();
    rd_reg(8'h20, 32'h4, "R6 lower base load");
    wr_reg(8'h20, 32'h4);

    vsel = 2'b10;
    vphase = 2'b01; cyc();
    rd_reg(8'h20, 0, "R5 no hit in back porch");
    vphase = 2'b10; cyc();
    rd_reg(8'h20, 32'h8, "R5 entry to active video");
    wr_reg(8'h20, 32'h8);
    cyc(); cyc();
    rd_reg(8'h20, 0, "R5 no retrigger inside phase");
    vphase = 2'b11; cyc();
    vphase = 2'b00; cyc();
    vphase = 2'b10; cyc();
    rd_reg(8'h20, 32'h8, "R5 second entry");
    wr_reg(8'h20, 32'h8);
    vsel = 2'b10; vphase = 2'b10; cyc();

    merr = 1; cyc();
    check("R8 err_state set", {31'b0, err_st}, 1);
    cyc(); cyc();
    check("R8 err_state held", {31'b0, err_st}, 1);
    wr_reg(8'h20, 32'h10);
    check("R8 err_state cleared", {31'b0, err_st}, 0);

    uu = 1; sel = 1; wr = 1; addr = 8'h20; wdata = 32'h2; cyc();
    rd_reg(8'h20, 32'h2, "R4 set wins over clear");
    wr_reg(8'h20, 32'h2);

    merr = 1; ul = 1; cyc();
    wr_reg(8'h20, 32'hFFFF_FFE1);
    rd_reg(8'h20, 32'h14, "R2 reserved bits ignored and read zero");
    wr_reg(8'h1C, 32'hFFFF_FFFF);
    rd_reg(8'h1C, 32'h1E, "R9 mask bits 4:1 writable");
    wr_reg(8'h1C, 32'h0);
    check("R10 irq low with mask clear", {31'b0, irq}, 0);
    wr_reg(8'h1C, 32'h4);
    check("R10 irq high on enabled bit", {31'b0, irq}, 1);
    rd_reg(8'h24, 32'h4, "R10 masked status");
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_reg(8'h24, 32'h4, "R10 masked status write ignored");
    rd_reg(8'h20, 32'h14, "R10 masked write leaves status");
    rd_reg(8'h00, 0, "R11 unmapped offset");
    cyc();
    check("R11 idle rdata zero", rdata, 0);
    wr_reg(8'h20, 32'h1E);
    check("R10 irq low after clear", {31'b0, irq}, 0);

    for (int i = 0; i < 40; i++) begin
      vphase = 2'(i % 4); vsel = 2'((i / 7) % 4);
      uu = (i % 5 == 0); ll = (i % 6 == 1); merr = (i % 9 == 2);
      sel = (i % 2 == 0); wr = (i % 4 == 0);
      addr = (i % 3 == 0) ? 8'h20 : ((i % 3 == 1) ? 8'h1C : 8'h24);
      wdata = 32'(i * 7);
      cyc();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule